// File: doc/BRIEF.md
# Protected Register Write Gate

The block sits between a simple register bus and a small group of system control registers that must not be changed by accident. The protection stays on until software writes a fixed three-byte code, one byte per write, into the key register. While the protection is on, a write aimed at a guarded register still reaches it, but every guarded bit is replaced by the value the register already holds. A register whose bits are all guarded receives no write enable at all. Bits left out of a register's guard mask can always be written.

Each guarded register is described by its bus offset and a 32-bit guard mask. The mask can cover a whole register, only a few low bits, or everything except one or two exempt bits. The block produces one write enable per guarded register and a single shared data word with the guarded bits merged in. The registers themselves, and the value sources that feed `tgt_cur`, sit outside this block.

Top module: `prot_key_guard`

## Requirements
- R1: After reset the gate is locked, and a read of the key register at offset 0x100 returns 0.
- R2: Three writes to offset 0x100 with low bytes 0x59, 0x16 and 0x88, in that order, unlock the gate. The key register reads 1 from the cycle after the third write.
- R3: A read at offset 0x100 returns the unlock status in bit 0 and zeros in bits 31:1. A read at any other offset returns 0. The result is combinational on `bus_addr`.
- R4: A key byte that breaks the order returns the sequence to its start. If that byte is 0x59, it counts as the first byte of a new attempt.
- R5: A write to any offset other than 0x100 in the middle of the sequence cancels the sequence.
- R6: While unlocked, any write to offset 0x100, whatever its value, locks the gate again from the next cycle.
- R7: While locked, a write to a partly guarded register asserts that register's enable. The data word carries the written value in unguarded bits and `tgt_cur` in guarded bits. Target 0 is at 0x008 with mask 0x00000003, target 1 at 0x018 with mask 0x000000AF, and target 3 at 0x200 with mask 0xFFFFFFBF.
- R8: While locked, a write to a fully guarded register, target 2 at 0x024 with mask 0xFFFFFFFF, asserts no enable.
- R9: While unlocked, a write to any target asserts its enable in the same cycle and forwards `bus_wdata` unchanged.
- R10: At most one target enable is high at a time. It is high only in a cycle where `bus_we` is high and `bus_addr` equals that target's offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 32 | Read data for the key register |
| unlocked | output | 1 | High while guarded writes are allowed |
| tgt_cur | input | 4x32 | Current contents of each guarded register |
| tgt_we | output | 4 | Per-target write enable after filtering |
| tgt_wdata | output | 32 | Write data with guarded bits merged while locked |

## Verification
Every cycle, the assertions check the following. Unlocking always follows a 0x88 key write. A key write while unlocked locks the gate. A write elsewhere never unlocks it. Target enables are one-hot and tied to `bus_we`. Guarded bits on a locked write equal `tgt_cur`, and unlocked writes pass through unchanged. Only the bench scenarios can show the sequence behaviour: restart on 0x59, abort on a foreign write, a wrong third byte, and repeated lock and unlock cycles. The bench compares these against its own model of the sequence, together with the exact merged data words for each mask.

// File: rtl/pkey_pkg.sv
package pkey_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int NTGT   = 4;

  localparam logic [ADDR_W-1:0] KEY_ADDR = 12'h100;
  localparam logic [7:0] KEY_B0 = 8'h59;
  localparam logic [7:0] KEY_B1 = 8'h16;
  localparam logic [7:0] KEY_B2 = 8'h88;

  // index 0 at the right
  localparam logic [NTGT-1:0][ADDR_W-1:0] TGT_ADDR =
    {12'h200, 12'h024, 12'h018, 12'h008};
  localparam logic [NTGT-1:0][DATA_W-1:0] TGT_MASK =
    {32'hFFFF_FFBF, 32'hFFFF_FFFF, 32'h0000_00AF, 32'h0000_0003};

  typedef enum logic [1:0] {
    KS_IDLE = 2'd0,
    KS_ONE  = 2'd1,
    KS_TWO  = 2'd2,
    KS_OPEN = 2'd3
  } key_state_e;
endpackage

// File: rtl/pkey_rst_sync.sv
module pkey_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= 2'b00;
    else        stg_q <= {stg_q[0], 1'b1};
  end

  assign rst_n_sync = stg_q[1];
endmodule

// File: rtl/pkey_seq_fsm.sv
module pkey_seq_fsm
  import pkey_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_wr,
  input  logic       other_wr,
  input  logic [7:0] key_byte,
  output logic       open
);
  key_state_e st_q, st_d;
  logic       st_en;

  // the state moves only on a bus write
  assign st_en = key_wr | other_wr;

  always_comb begin
    st_d = st_q;
    if (key_wr) begin
      unique case (st_q)
        KS_IDLE: st_d = (key_byte == KEY_B0) ? KS_ONE : KS_IDLE;
        KS_ONE:  st_d = (key_byte == KEY_B1) ? KS_TWO :
                        (key_byte == KEY_B0) ? KS_ONE : KS_IDLE;
        KS_TWO:  st_d = (key_byte == KEY_B2) ? KS_OPEN :
                        (key_byte == KEY_B0) ? KS_ONE : KS_IDLE;
        KS_OPEN: st_d = KS_IDLE;
        default: st_d = KS_IDLE;
      endcase
    end else if (other_wr && st_q != KS_OPEN) begin
      st_d = KS_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= KS_IDLE;
    else if (st_en) st_q <= st_d;
  end

  assign open = (st_q == KS_OPEN);
endmodule

// File: rtl/pkey_wr_filter.sv
module pkey_wr_filter
  import pkey_pkg::*;
#(
  parameter int N  = NTGT,
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic                 open,
  input  logic [AW-1:0]        addr,
  input  logic [DW-1:0]        wdata,
  input  logic                 we,
  input  logic [N-1:0][DW-1:0] cur,
  output logic [N-1:0]         tgt_we,
  output logic [DW-1:0]        tgt_wdata
);
  logic [N-1:0]         hit;
  logic [N-1:0][DW-1:0] merged;

  for (genvar i = 0; i < N; i++) begin : g_tgt
    localparam logic [DW-1:0] M    = TGT_MASK[i];
    localparam bit            FULL = (M == {DW{1'b1}});
    assign hit[i]    = we && (addr == TGT_ADDR[i]);
    assign merged[i] = open ? wdata : ((wdata & ~M) | (cur[i] & M));
    if (FULL) begin : g_full
      assign tgt_we[i] = hit[i] & open;
    end else begin : g_part
      assign tgt_we[i] = hit[i];
    end
  end

  always_comb begin
    tgt_wdata = wdata;
    for (int i = 0; i < N; i++) begin
      if (hit[i]) tgt_wdata = merged[i];
    end
  end
endmodule

// File: rtl/prot_key_guard.sv
module prot_key_guard
  import pkey_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [DATA_W-1:0]       bus_wdata,
  input  logic                    bus_we,
  output logic [DATA_W-1:0]       bus_rdata,
  output logic                    unlocked,
  input  logic [NTGT-1:0][DATA_W-1:0] tgt_cur,
  output logic [NTGT-1:0]         tgt_we,
  output logic [DATA_W-1:0]       tgt_wdata
);
  logic rst_n_s;
  logic key_hit;

  pkey_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  assign key_hit = (bus_addr == KEY_ADDR);

  pkey_seq_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .key_wr   (bus_we & key_hit),
    .other_wr (bus_we & ~key_hit),
    .key_byte (bus_wdata[7:0]),
    .open     (unlocked)
  );

  pkey_wr_filter u_flt (
    .open      (unlocked),
    .addr      (bus_addr),
    .wdata     (bus_wdata),
    .we        (bus_we),
    .cur       (tgt_cur),
    .tgt_we    (tgt_we),
    .tgt_wdata (tgt_wdata)
  );

  assign bus_rdata = key_hit ? {{(DATA_W-1){1'b0}}, unlocked} : '0;
endmodule

// File: rtl/prot_key_guard_chk.sv
module prot_key_guard_chk
  import pkey_pkg::*;
(
  input logic                        clk,
  input logic                        rst_n,
  input logic [ADDR_W-1:0]           bus_addr,
  input logic [DATA_W-1:0]           bus_wdata,
  input logic                        bus_we,
  input logic [DATA_W-1:0]           bus_rdata,
  input logic                        unlocked,
  input logic [NTGT-1:0][DATA_W-1:0] tgt_cur,
  input logic [NTGT-1:0]             tgt_we,
  input logic [DATA_W-1:0]           tgt_wdata
);
  a_r2_unlock_after_last_byte: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(bus_we && bus_addr == KEY_ADDR && bus_wdata[7:0] == KEY_B2));

  a_r6_key_write_relocks: assert property (@(posedge clk) disable iff (!rst_n)
    (unlocked && bus_we && bus_addr == KEY_ADDR) |=> !unlocked);

  a_r5_foreign_write_no_unlock: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && bus_we && bus_addr != KEY_ADDR) |=> !unlocked);

  a_r3_readback_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DATA_W-1:1] == '0);

  a_r10_onehot_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tgt_we));

  a_r10_no_enable_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |-> tgt_we == '0);

  a_r9_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
    (unlocked && tgt_we != '0) |-> tgt_wdata == bus_wdata);

  for (genvar i = 0; i < NTGT; i++) begin : g_mask
    a_r7_guarded_bits_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (!unlocked && tgt_we[i]) |-> ((tgt_wdata & TGT_MASK[i]) == (tgt_cur[i] & TGT_MASK[i])));
  end
endmodule

bind prot_key_guard prot_key_guard_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_we    (bus_we),
  .bus_rdata (bus_rdata),
  .unlocked  (unlocked),
  .tgt_cur   (tgt_cur),
  .tgt_we    (tgt_we),
  .tgt_wdata (tgt_wdata)
);

// File: tb/prot_key_guard_tb.sv
module prot_key_guard_tb;
  logic              clk;
  logic              rst_n;
  logic [11:0]       bus_addr;
  logic [31:0]       bus_wdata;
  logic              bus_we;
  logic [31:0]       bus_rdata;
  logic              unlocked;
  logic [3:0][31:0]  tgt_cur;
  logic [3:0]        tgt_we;
  logic [31:0]       tgt_wdata;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  int mst    = 0;  // 0 idle, 1 one byte, 2 two bytes, 3 open

  localparam logic [11:0] KA = 12'h100;
  logic [3:0][11:0] ta;
  logic [3:0][31:0] tm;

  prot_key_guard u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .unlocked(unlocked),
    .tgt_cur(tgt_cur), .tgt_we(tgt_we), .tgt_wdata(tgt_wdata)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  function automatic int next_st(int s, logic [11:0] a, logic [31:0] d, logic w);
    if (!w) return s;
    if (a == KA) begin
      if (s == 3) return 0;
      if (s == 0) return (d[7:0] == 8'h59) ? 1 : 0;
      if (s == 1) return (d[7:0] == 8'h16) ? 2 : (d[7:0] == 8'h59) ? 1 : 0;
      return (d[7:0] == 8'h88) ? 3 : (d[7:0] == 8'h59) ? 1 : 0;
    end
    return (s == 3) ? 3 : 0;
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(logic [11:0] a, logic [31:0] d, logic w, string tag);
    logic [3:0]  ewe;
    logic [31:0] ewd;
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = w;
    #2;
    ewe = '0; ewd = d;
    for (int i = 0; i < 4; i++) begin
      if (w && a == ta[i]) begin
        ewe[i] = (mst == 3) || (tm[i] != 32'hFFFF_FFFF);
        ewd    = (mst == 3) ? d : ((d & ~tm[i]) | (tgt_cur[i] & tm[i]));
      end
    end
    chk(bus_rdata == ((a == KA) ? {31'b0, mst == 3} : 32'b0), {tag, " R3 rdata"}, bus_rdata,
        (a == KA) ? {31'b0, mst == 3} : 32'b0);
    chk(tgt_we == ewe, {tag, " R8 R10 tgt_we"}, {28'b0, tgt_we}, {28'b0, ewe});
    if (ewe != '0) chk(tgt_wdata == ewd, {tag, " R7 R9 tgt_wdata"}, tgt_wdata, ewd);
    mst = next_st(mst, a, d, w);
  endtask

  task automatic expect_open(bit e, string tag);
    step(KA, 32'h0, 1'b0, tag);
    chk(unlocked == e, {tag, " status"}, {31'b0, unlocked}, {31'b0, e});
  endtask

  task automatic key3;
    step(KA, 32'h59, 1'b1, "R2");
    step(KA, 32'h16, 1'b1, "R2");
    step(KA, 32'h88, 1'b1, "R2");
  endtask

  initial begin
    ta = {12'h200, 12'h024, 12'h018, 12'h008};
    tm = {32'hFFFF_FFBF, 32'hFFFF_FFFF, 32'h0000_00AF, 32'h0000_0003};
    void'($urandom(32'd4242));
    rst_n = 0; bus_addr = '0; bus_wdata = '0; bus_we = 0; tgt_cur = '0;
    repeat (3) @(posedge clk);
    rst_n = 1;
    repeat (3) @(posedge clk);

    expect_open(0, "R1");
    key3();
    expect_open(1, "R2");
    tgt_cur = '0;
    step(12'h018, 32'hFFFF_FFFF, 1'b1, "R9");
    step(12'h024, 32'h0000_5AA5, 1'b1, "R9");
    step(KA, 32'h1234_5678, 1'b1, "R6");
    expect_open(0, "R6");
    step(KA, 32'h59, 1'b1, "R4");
    step(KA, 32'h16, 1'b1, "R4");
    step(KA, 32'h59, 1'b1, "R4");
    step(KA, 32'h16, 1'b1, "R4");
    step(KA, 32'h88, 1'b1, "R4");
    expect_open(1, "R4");
    step(KA, 32'h0, 1'b1, "R6");
    step(KA, 32'h59, 1'b1, "R4");
    step(KA, 32'h16, 1'b1, "R4");
    step(KA, 32'h12, 1'b1, "R4");
    step(KA, 32'h88, 1'b1, "R4");
    expect_open(0, "R4");
    step(KA, 32'h59, 1'b1, "R5");
    step(12'h018, 32'h0, 1'b1, "R5");
    step(KA, 32'h16, 1'b1, "R5");
    step(KA, 32'h88, 1'b1, "R5");
    expect_open(0, "R5");
    tgt_cur = {32'h0, 32'h0, 32'h0, 32'h0};
    step(12'h018, 32'hFFFF_FFFF, 1'b1, "R7");
    chk(tgt_wdata == 32'hFFFF_FF50, "R7 partial mask", tgt_wdata, 32'hFFFF_FF50);
    step(12'h200, 32'hFFFF_FFFF, 1'b1, "R7");
    chk(tgt_wdata == 32'h0000_0040, "R7 exempt bit", tgt_wdata, 32'h0000_0040);
    tgt_cur[0] = 32'h0000_0002;
    step(12'h008, 32'h0000_0001, 1'b1, "R7");
    chk(tgt_wdata == 32'h0000_0002, "R7 low bits", tgt_wdata, 32'h0000_0002);
    step(12'h024, 32'h0000_5AA5, 1'b1, "R8");
    chk(tgt_we == 4'b0000, "R8 full mask", {28'b0, tgt_we}, 32'h0);
    step(12'h024, 32'h0, 1'b0, "R10");

    for (int n = 0; n < 4000; n++) begin
      logic [11:0] a;
      logic [31:0] d;
      int k;
      tgt_cur = {$urandom, $urandom, $urandom, $urandom};
      k = $urandom_range(0, 9);
      d = $urandom;
      if (k < 5) begin
        a = KA;
        if ($urandom_range(0, 3) != 0)
          d[7:0] = (mst == 0) ? 8'h59 : (mst == 1) ? 8'h16 : (mst == 2) ? 8'h88 : d[7:0];
      end else if (k < 9) a = ta[$urandom_range(0, 3)];
      else                a = 12'($urandom);
      step(a, d, 1'($urandom_range(0, 3) != 0), "RND");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule